// File: doc/BRIEF.md
# Logical Thread Enumeration Sequencer

This block runs on the host side of a processor management link. It finds out which logical threads in a package can be reached. After a start pulse it walks the candidate thread numbers upward from zero. For each number it sends one register-read probe over a simple request/response interface, then waits for that probe's reply before it moves on. Each reply is sorted by its completion code. The block builds a 16-bit map with one bit per thread number, and a count of the threads found.

Thread numbers are tied to fixed physical positions. A thread that has been switched off therefore leaves a zero gap in the map, and the thread numbers above it keep their own bit positions. The caller can give a highest thread number at start, for example one read earlier from the package, and the scan then stops at that number. A probe that gets no reply within a set number of cycles counts as a missing thread and raises the error flag. The error flag also rises for any completion code the block does not recognise.

Top module: `lthread_scanner`

## Requirements
- R1: A start pulse while idle clears the presence map, the count and the error flag. The scan then begins at thread number 0, and busy stays high until the last probe is classified.
- R2: Thread numbers are probed in strictly ascending order with step 1. Every request carries command byte 0xB1, write length 0x05 and read length 0x09, and holds its valid, number and fields until ready is seen high.
- R3: At most one probe is outstanding. No new request is raised until the current probe has received its reply or has timed out.
- R4: A reply with completion code 0x40 sets bit i of the presence map, where i is the probed thread number. No other bit moves.
- R5: A reply with completion code 0x90 leaves bit i clear and does not raise the error flag.
- R6: A reply with any other completion code leaves bit i clear and sets the error flag. The flag stays set until the next accepted start.
- R7: If no reply arrives within TIMEOUT_CYCLES cycles after the request is accepted, the probe is treated as a missing thread, bit i stays clear, and the error flag is set.
- R8: If the limit-enable input is high at start, the scan covers thread numbers 0 through the supplied highest number, inclusive. Otherwise it covers 0 through 15.
- R9: The count output always equals the number of set bits in the presence map.
- R10: Done is high for exactly one cycle, in the cycle after the last probe is classified. In that cycle busy is already low, and the results hold until the next start.
- R11: A start pulse during a scan is ignored. The scan continues and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a scan (accepted only while idle) |
| limit_en_i | input | 1 | Use max_id_i as the last thread number of the scan |
| max_id_i | input | 4 | Highest thread number to probe when the limit is enabled |
| req_valid_o | output | 1 | Probe request valid |
| req_ready_i | input | 1 | Transport accepts the probe request |
| req_id_o | output | 4 | Thread number being probed |
| req_cmd_o | output | 8 | Command byte of the probe (0xB1) |
| req_wlen_o | output | 8 | Write length of the probe (0x05) |
| req_rlen_o | output | 8 | Read length of the probe (0x09) |
| rsp_valid_i | input | 1 | Reply strobe for the outstanding probe |
| rsp_cc_i | input | 8 | Completion code of the reply |
| present_o | output | 16 | Presence map, bit i for thread number i |
| count_o | output | 5 | Number of threads found present |
| err_o | output | 1 | Sticky error: unknown completion code or timeout |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when the scan has finished |

## Verification
The assertions check five things on every cycle:
- the count always matches the popcount of the map;
- done lasts one cycle and never overlaps busy;
- a stalled request keeps its thread number and valid;
- the error flag cannot drop during a scan;
- no waiting period runs longer than the timeout.

Only the bench scenarios can show the rest. That covers the mapping of completion codes to map bits and to the error flag, holes staying at their physical positions, the limit setting the last probed number, the ascending probe order and fixed command fields, and a start pulse during a scan being ignored.

// File: rtl/thread_enum_pkg.sv
package thread_enum_pkg;

    localparam int unsigned NUM_IDS = 16;
    localparam int unsigned ID_W    = $clog2(NUM_IDS);
    localparam int unsigned CNT_W   = $clog2(NUM_IDS + 1);
    localparam int unsigned BYTE_W  = 8;

    localparam logic [BYTE_W-1:0] PROBE_OPCODE = 8'hB1;
    localparam logic [BYTE_W-1:0] PROBE_WR_LEN = 8'h05;
    localparam logic [BYTE_W-1:0] PROBE_RD_LEN = 8'h09;
    localparam logic [BYTE_W-1:0] CC_PRESENT   = 8'h40;
    localparam logic [BYTE_W-1:0] CC_ABSENT    = 8'h90;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } scan_state_e;

    typedef enum logic [1:0] {
        VERDICT_PRESENT,
        VERDICT_ABSENT,
        VERDICT_FAULT,
        VERDICT_SILENT
    } verdict_e;

    typedef struct packed {
        logic     valid;
        verdict_e verdict;
    } probe_result_t;

    function automatic verdict_e classify_cc(input logic [BYTE_W-1:0] cc);
        verdict_e v;
        if (cc == CC_PRESENT)      v = VERDICT_PRESENT;
        else if (cc == CC_ABSENT)  v = VERDICT_ABSENT;
        else                       v = VERDICT_FAULT;
        return v;
    endfunction

    function automatic logic verdict_is_error(input verdict_e v);
        return (v == VERDICT_FAULT) || (v == VERDICT_SILENT);
    endfunction

endpackage

// File: rtl/id_stepper.sv
module id_stepper
    import thread_enum_pkg::*;
#(
    parameter int unsigned W = ID_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         limit_en,
    input  logic [W-1:0] limit,
    input  logic         advance,
    output logic [W-1:0] id,
    output logic         is_last
);
    localparam logic [W-1:0] TOP_ID = {W{1'b1}};

    logic [W-1:0] id_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q   <= '0;
            last_q <= TOP_ID;
        end else if (load) begin
            id_q   <= '0;
            last_q <= limit_en ? limit : TOP_ID;
        end else if (advance) begin
            id_q   <= id_q + 1'b1;
        end
    end

    assign id      = id_q;
    assign is_last = (id_q == last_q);
endmodule

// File: rtl/probe_timer.sv
module probe_timer #(
    parameter int unsigned CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned TW = $clog2(CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/reply_classifier.sv
module reply_classifier
    import thread_enum_pkg::*;
(
    input  logic              waiting,
    input  logic              rsp_valid,
    input  logic [BYTE_W-1:0] rsp_cc,
    input  logic              timed_out,
    output probe_result_t     result
);
    always_comb begin
        result.valid   = 1'b0;
        result.verdict = VERDICT_ABSENT;
        if (waiting) begin
            if (rsp_valid) begin
                result.valid   = 1'b1;
                result.verdict = classify_cc(rsp_cc);
            end else if (timed_out) begin
                result.valid   = 1'b1;
                result.verdict = VERDICT_SILENT;
            end
        end
    end
endmodule

// File: rtl/presence_accum.sv
module presence_accum
    import thread_enum_pkg::*;
#(
    parameter int unsigned N = NUM_IDS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  probe_result_t        result,
    input  logic [$clog2(N)-1:0] id,
    output logic [N-1:0]         present,
    output logic [$clog2(N+1)-1:0] count,
    output logic                 err
);
    logic [N-1:0]             present_q;
    logic [$clog2(N+1)-1:0]   count_q;
    logic                     err_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            present_q <= '0;
            count_q   <= '0;
            err_q     <= 1'b0;
        end else if (result.valid) begin
            if (result.verdict == VERDICT_PRESENT) begin
                present_q[id] <= 1'b1;
                count_q       <= count_q + 1'b1;
            end
            if (verdict_is_error(result.verdict)) begin
                err_q <= 1'b1;
            end
        end
    end

    assign present = present_q;
    assign count   = count_q;
    assign err     = err_q;
endmodule

// File: rtl/lthread_scanner.sv
module lthread_scanner
    import thread_enum_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              limit_en_i,
    input  logic [ID_W-1:0]   max_id_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ID_W-1:0]   req_id_o,
    output logic [BYTE_W-1:0] req_cmd_o,
    output logic [BYTE_W-1:0] req_wlen_o,
    output logic [BYTE_W-1:0] req_rlen_o,
    input  logic              rsp_valid_i,
    input  logic [BYTE_W-1:0] rsp_cc_i,
    output logic [NUM_IDS-1:0] present_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              err_o,
    output logic              busy_o,
    output logic              done_o
);
    scan_state_e   state_q, state_d;
    logic          done_q;
    logic          accept_start;
    logic          advance;
    logic          is_last;
    logic          timed_out;
    logic [ID_W-1:0] cur_id;
    probe_result_t result;

    assign accept_start = (state_q == ST_IDLE) && start_i;
    assign advance      = result.valid && !is_last;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start_i)     state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready_i) state_d = ST_WAIT;
            ST_WAIT:  if (result.valid) state_d = is_last ? ST_IDLE : ST_ISSUE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_WAIT) && result.valid && is_last;
        end
    end

    id_stepper #(.W(ID_W)) u_stepper (
        .clk      (clk),
        .rst      (rst),
        .load     (accept_start),
        .limit_en (limit_en_i),
        .limit    (max_id_i),
        .advance  (advance),
        .id       (cur_id),
        .is_last  (is_last)
    );

    probe_timer #(.CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == ST_WAIT),
        .expired (timed_out)
    );

    reply_classifier u_classify (
        .waiting   (state_q == ST_WAIT),
        .rsp_valid (rsp_valid_i),
        .rsp_cc    (rsp_cc_i),
        .timed_out (timed_out),
        .result    (result)
    );

    presence_accum #(.N(NUM_IDS)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept_start),
        .result  (result),
        .id      (cur_id),
        .present (present_o),
        .count   (count_o),
        .err     (err_o)
    );

    assign req_valid_o = (state_q == ST_ISSUE);
    assign req_id_o    = cur_id;
    assign req_cmd_o   = PROBE_OPCODE;
    assign req_wlen_o  = PROBE_WR_LEN;
    assign req_rlen_o  = PROBE_RD_LEN;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
endmodule

// File: rtl/lthread_scanner_chk.sv
module lthread_scanner_chk
    import thread_enum_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ID_W-1:0]   req_id_o,
    input logic [NUM_IDS-1:0] present_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              err_o,
    input logic              busy_o,
    input logic              done_o
);
    localparam int unsigned WW = $clog2(TIMEOUT_CYCLES + 2);

    logic [WW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy_o || req_valid_o) wait_cnt <= '0;
        else                               wait_cnt <= wait_cnt + 1'b1;
    end

    p_count_matches_r9: assert property (@(posedge clk) disable iff (rst)
        count_o == CNT_W'($countones(present_o)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_id_o)));

    p_req_only_busy_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> busy_o);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && err_o) |=> err_o);

    p_wait_bounded_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !req_valid_o) |-> (wait_cnt < WW'(TIMEOUT_CYCLES)));
endmodule

bind lthread_scanner lthread_scanner_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_id_o    (req_id_o),
    .present_o   (present_o),
    .count_o     (count_o),
    .err_o       (err_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/lthread_scanner_bench.sv
`timescale 1ns/1ps
module lthread_scanner_bench;
    localparam int unsigned TO = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        limit_en_i = 1'b0;
    logic [3:0]  max_id_i = 4'd0;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic [3:0]  req_id_o;
    logic [7:0]  req_cmd_o, req_wlen_o, req_rlen_o;
    logic        rsp_valid_i = 1'b0;
    logic [7:0]  rsp_cc_i = 8'h00;
    logic [15:0] present_o;
    logic [4:0]  count_o;
    logic        err_o, busy_o, done_o;

    int tests = 0;
    int fails = 0;

    logic [7:0]  cc_tbl [16];
    logic [15:0] silent_mask = '0;
    int          ready_dly = 0;
    int          rsp_lat = 1;
    int          exp_next_id = 0;
    int          field_errs = 0;

    always #2 clk = ~clk;

    lthread_scanner #(.TIMEOUT_CYCLES(TO)) u_lthread_scanner (
        .clk(clk), .rst(rst), .start_i(start_i), .limit_en_i(limit_en_i),
        .max_id_i(max_id_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_id_o(req_id_o), .req_cmd_o(req_cmd_o), .req_wlen_o(req_wlen_o),
        .req_rlen_o(req_rlen_o), .rsp_valid_i(rsp_valid_i), .rsp_cc_i(rsp_cc_i),
        .present_o(present_o), .count_o(count_o), .err_o(err_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Transport model: accepts each request after ready_dly cycles and replies after rsp_lat.
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid_o) begin
                if (req_id_o != 4'(exp_next_id) || req_cmd_o != 8'hB1 ||
                    req_wlen_o != 8'h05 || req_rlen_o != 8'h09)
                    field_errs++;
                exp_next_id++;
                for (int k = 0; k < ready_dly; k++) begin
                    @(negedge clk);
                    if (!req_valid_o || req_id_o != 4'(exp_next_id - 1)) field_errs++;
                end
                req_ready_i = 1'b1;
                @(negedge clk);
                req_ready_i = 1'b0;
                if (!silent_mask[exp_next_id - 1]) begin
                    for (int k = 0; k < rsp_lat; k++) begin
                        @(negedge clk);
                        if (req_valid_o) field_errs++;
                    end
                    rsp_valid_i = 1'b1;
                    rsp_cc_i    = cc_tbl[exp_next_id - 1];
                    @(negedge clk);
                    rsp_valid_i = 1'b0;
                    rsp_cc_i    = 8'h00;
                end
            end
        end
    end

    task automatic set_all(input logic [7:0] cc);
        for (int i = 0; i < 16; i++) cc_tbl[i] = cc;
        silent_mask = '0;
    endtask

    // Runs one scan and compares results with values derived from cc_tbl and silent_mask.
    task automatic run_scan(input string tag, input bit lim, input int last, input int stray_start_at);
        logic [15:0] exp_map = '0;
        int          exp_cnt = 0;
        bit          exp_err = 0;
        int          cyc = 0;
        bit          busy_ok = 1;
        for (int i = 0; i <= last; i++) begin
            if (silent_mask[i]) exp_err = 1;
            else if (cc_tbl[i] == 8'h40) begin exp_map[i] = 1'b1; exp_cnt++; end
            else if (cc_tbl[i] != 8'h90) exp_err = 1;
        end
        exp_next_id = 0;
        field_errs  = 0;
        @(negedge clk);
        limit_en_i = lim;
        max_id_i   = 4'(last);
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        check(busy_o && count_o == 0 && present_o == 0 && !err_o, {tag, " R1 clear+busy"},
              {busy_o, count_o, present_o}, {1'b1, 21'd0});
        while (!done_o && cyc < 5000) begin
            if (!busy_o) busy_ok = 0;
            cyc++;
            if (cyc == stray_start_at) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        check(done_o, {tag, " R10 done seen"}, done_o, 1);
        check(!busy_o, {tag, " R10 busy low at done"}, busy_o, 0);
        check(busy_ok, {tag, " R1 busy held during scan"}, busy_ok, 1);
        check(present_o == exp_map, {tag, " R4/R5 presence map"}, present_o, exp_map);
        check(count_o == 5'(exp_cnt), {tag, " R9 count"}, count_o, exp_cnt);
        check(err_o == exp_err, {tag, " R6/R7 error flag"}, err_o, exp_err);
        check(exp_next_id == last + 1, {tag, " R8 probe count"}, exp_next_id, last + 1);
        check(field_errs == 0, {tag, " R2/R3 request order and fields"}, field_errs, 0);
        @(negedge clk);
        check(!done_o, {tag, " R10 done one cycle"}, done_o, 0);
        check(present_o == exp_map && count_o == 5'(exp_cnt), {tag, " R10 results hold"},
              present_o, exp_map);
    endtask

    task automatic t_reset;
        check(!busy_o && !done_o && !req_valid_o && present_o == 0 && count_o == 0 && !err_o,
              "R1 reset state", {busy_o, done_o, req_valid_o, err_o}, 0);
    endtask

    task automatic t_all_present;
        set_all(8'h40); ready_dly = 0; rsp_lat = 1;
        run_scan("all-present", 1'b0, 15, 0);
    endtask

    task automatic t_holes;
        set_all(8'h40); ready_dly = 2; rsp_lat = 3;
        cc_tbl[1] = 8'h90; cc_tbl[2] = 8'h90; cc_tbl[9] = 8'h90; cc_tbl[15] = 8'h90;
        run_scan("holes R5", 1'b0, 15, 0);
    endtask

    task automatic t_limit;
        set_all(8'h40); ready_dly = 1; rsp_lat = 0;
        cc_tbl[3] = 8'h90;
        run_scan("limit5 R8", 1'b1, 5, 0);
        run_scan("limit0 R8", 1'b1, 0, 0);
        run_scan("limit15 R8", 1'b1, 15, 0);
    endtask

    task automatic t_bad_code;
        set_all(8'h90); ready_dly = 0; rsp_lat = 1;
        cc_tbl[0] = 8'h40; cc_tbl[3] = 8'h80; cc_tbl[12] = 8'h40;
        run_scan("badcc R6", 1'b0, 15, 0);
    endtask

    task automatic t_timeout;
        set_all(8'h40); ready_dly = 0; rsp_lat = 2;
        silent_mask[7] = 1'b1;
        run_scan("timeout R7", 1'b0, 15, 0);
    endtask

    task automatic t_restart_clears;
        set_all(8'h40); ready_dly = 0; rsp_lat = 1;
        run_scan("restart R1", 1'b1, 3, 0);
    endtask

    task automatic t_start_while_busy;
        set_all(8'h40); ready_dly = 0; rsp_lat = 1;
        cc_tbl[4] = 8'h90;
        run_scan("stray-start R11", 1'b0, 15, 20);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) cc_tbl[i] = 8'h40;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_all_present();
        t_holes();
        t_limit();
        t_bad_code();
        t_timeout();
        t_restart_clears();
        t_start_while_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule